// File: doc/BRIEF.md
# Bit Test-and-Modify Unit

This unit executes the four single-bit test operations on 32-bit operands: plain test, test-and-set, test-and-reset and test-and-complement. Each command selects one bit of a dword, reports that bit's original value as the carry flag, and (except for plain test) returns or stores the dword with that bit changed. Commands arrive on a valid/ready stream and results leave on a second valid/ready stream. A stalled result holds its payload until the consumer takes it, and no new command is accepted until then.

A command either works on a register operand carried in the command, or on memory. A memory command with a register offset may reach any bit relative to a base address. The offset is split into a signed dword displacement and a bit index within the dword, and the resulting byte address wraps to the active address size. A memory command with an immediate offset keeps the base address and uses only the offset's bit index. Memory commands perform a read over a simple request/response port and, for the modifying operations, a write of the updated dword to the same address.

The flag word presented with the command is returned with its carry bit replaced. All other flag bits are passed through unchanged.

Top module: `bitop_unit`

## Requirements
- R1: The selected bit index is the offset's low 5 bits (offset modulo 32), for register, memory and immediate forms alike.
- R2: res_cf equals the selected bit's value before modification. res_flags equals cmd_flags with bit 0 (the carry position) replaced by that value.
- R3: cmd_op encoding: 0 = test (value unchanged), 1 = set the bit to 1, 2 = reset the bit to 0, 3 = complement the bit. All other bits of the dword are unchanged.
- R4: A register-form command (cmd_mem=0) issues no memory request and returns the modified operand on res_value.
- R5: A memory command with a register offset accesses base + 4 * floor(offset / 32), where the offset is taken as a signed 32-bit value.
- R6: cmd_asize 0 truncates the address to 16 bits, 1 truncates it to 32 bits, and 2 or 3 keeps the full 64 bits. Upper bits are zero after truncation.
- R7: A memory command with an immediate offset (cmd_imm=1) accesses the base address (wrapped per R6). Offset bits above the low 5 have no effect.
- R8: Memory forms of operations 1 to 3 read one dword and then write the modified dword to the same address. Plain test reads only and writes nothing. res_value returns the read dword for test and the modified dword otherwise.
- R9: mem_req, once raised, stays high with stable mem_addr, mem_we and mem_wdata until a cycle with mem_rvalid high. mem_rvalid completes both reads and writes.
- R10: cmd_ready is high only while the unit is idle. res_valid, once high, stays high with a stable payload until res_ready is high.
- R11: After reset, cmd_ready is 1 and res_valid and mem_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit accepts a command |
| cmd_op | input | 2 | Operation (R3 encoding) |
| cmd_mem | input | 1 | 1 = memory form, 0 = register form |
| cmd_imm | input | 1 | 1 = immediate offset (no displacement) |
| cmd_asize | input | 2 | Address size: 0 = 16, 1 = 32, 2/3 = 64 bits |
| cmd_operand | input | 32 | Register-form operand |
| cmd_offset | input | 32 | Bit offset (signed for memory register form) |
| cmd_base | input | 64 | Memory base byte address |
| cmd_flags | input | 32 | Incoming flag word, carry at bit 0 |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_value | output | 32 | Modified (or, for test, original) dword |
| res_cf | output | 1 | Original value of the selected bit |
| res_flags | output | 32 | Flag word with carry replaced |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Byte address of the dword |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Request completed (read data valid on reads) |
| mem_rdata | input | 32 | Read data |

## Verification
Random commands mix all four operations with the register, memory register-offset and memory immediate forms. Offsets span the full signed range and addresses span all three sizes. Register forms separate the bit-modify logic from the memory path. Memory forms show whether the displacement is floored and scaled correctly and whether the test operation avoids writing back. Directed cases cover the offset -1 (bit 31 of the dword 4 bytes below the base), carries that wrap at 16 and 32 bits, an immediate offset with high garbage bits, and a stalled result consumer.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [1:0] {
    OP_TEST  = 2'd0,
    OP_SET   = 2'd1,
    OP_RESET = 2'd2,
    OP_FLIP  = 2'd3
  } bit_op_e;

  typedef enum logic [1:0] {
    ASZ_16  = 2'd0,
    ASZ_32  = 2'd1,
    ASZ_64  = 2'd2,
    ASZ_64X = 2'd3
  } addr_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } unit_state_e;
endpackage

// File: rtl/bitop_addr_gen.sv
module bitop_addr_gen #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DATA_W-1:0] offset,
  input  logic              use_imm,
  input  logic [1:0]        asize,
  output logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  bit_idx
);
  import bitop_pkg::*;
  localparam int BYTE_SH = $clog2(DATA_W / 8);

  logic signed [DATA_W-1:0] word_disp;
  logic [ADDR_W-1:0]        disp_ext;
  logic [ADDR_W-1:0]        byte_disp;
  logic [ADDR_W-1:0]        raw_addr;

  assign bit_idx   = offset[IDX_W-1:0];
  // signed floor division by the word width in bits
  assign word_disp = $signed(offset) >>> IDX_W;
  assign disp_ext  = {{(ADDR_W-DATA_W){word_disp[DATA_W-1]}}, word_disp};
  assign byte_disp = disp_ext << BYTE_SH;
  assign raw_addr  = use_imm ? base : (base + byte_disp);

  always_comb begin
    case (addr_size_e'(asize))
      ASZ_16:  addr = {{(ADDR_W-16){1'b0}}, raw_addr[15:0]};
      ASZ_32:  addr = {{(ADDR_W-32){1'b0}}, raw_addr[31:0]};
      default: addr = raw_addr;
    endcase
  end
endmodule

// File: rtl/bitop_modify.sv
module bitop_modify #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] data_in,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] data_out,
  output logic              orig_bit
);
  import bitop_pkg::*;
  logic [DATA_W-1:0] sel_mask;

  assign sel_mask = {{(DATA_W-1){1'b0}}, 1'b1} << idx;
  assign orig_bit = data_in[idx];

  always_comb begin
    case (bit_op_e'(op))
      OP_SET:   data_out = data_in | sel_mask;
      OP_RESET: data_out = data_in & ~sel_mask;
      OP_FLIP:  data_out = data_in ^ sel_mask;
      default:  data_out = data_in;
    endcase
  end
endmodule

// File: rtl/bitop_ctrl.sv
module bitop_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic cmd_is_mem,
  input  logic held_is_test,
  input  logic mem_rvalid,
  input  logic res_ready,
  output logic cmd_ready,
  output logic mem_req,
  output logic mem_we,
  output logic res_valid,
  output logic load_cmd,
  output logic load_rdata
);
  import bitop_pkg::*;
  unit_state_e state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d    = state_q;
    load_cmd   = 1'b0;
    load_rdata = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          load_cmd = 1'b1;
          state_d  = cmd_is_mem ? ST_READ : ST_DONE;
        end
      end
      ST_READ: begin
        if (mem_rvalid) begin
          load_rdata = 1'b1;
          state_d    = held_is_test ? ST_DONE : ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (mem_rvalid) state_d = ST_DONE;
      end
      default: begin
        if (res_ready) state_d = ST_IDLE;
      end
    endcase
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we    = (state_q == ST_WRITE);
  assign res_valid = (state_q == ST_DONE);
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit #(
  parameter int ADDR_W  = 64,
  parameter int DATA_W  = 32,
  parameter int FLAGS_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_op,
  input  logic               cmd_mem,
  input  logic               cmd_imm,
  input  logic [1:0]         cmd_asize,
  input  logic [DATA_W-1:0]  cmd_operand,
  input  logic [DATA_W-1:0]  cmd_offset,
  input  logic [ADDR_W-1:0]  cmd_base,
  input  logic [FLAGS_W-1:0] cmd_flags,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [DATA_W-1:0]  res_value,
  output logic               res_cf,
  output logic [FLAGS_W-1:0] res_flags,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic               mem_rvalid,
  input  logic [DATA_W-1:0]  mem_rdata
);
  import bitop_pkg::*;
  localparam int IDX_W = $clog2(DATA_W);

  logic [1:0]         op_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [IDX_W-1:0]   idx_q;
  logic [DATA_W-1:0]  val_q;
  logic               cf_q;
  logic [FLAGS_W-1:1] flags_hi_q;

  logic [ADDR_W-1:0]  gen_addr;
  logic [IDX_W-1:0]   gen_idx;
  logic [1:0]         mod_op;
  logic [DATA_W-1:0]  mod_in;
  logic [IDX_W-1:0]   mod_idx;
  logic [DATA_W-1:0]  mod_out;
  logic               mod_bit;
  logic               load_cmd;
  logic               load_rdata;
  logic               held_is_test;

  assign held_is_test = (bit_op_e'(op_q) == OP_TEST);

  bitop_ctrl ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_is_mem   (cmd_mem),
    .held_is_test (held_is_test),
    .mem_rvalid   (mem_rvalid),
    .res_ready    (res_ready),
    .cmd_ready    (cmd_ready),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .res_valid    (res_valid),
    .load_cmd     (load_cmd),
    .load_rdata   (load_rdata)
  );

  bitop_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) agen_i (
    .base    (cmd_base),
    .offset  (cmd_offset),
    .use_imm (cmd_imm),
    .asize   (cmd_asize),
    .addr    (gen_addr),
    .bit_idx (gen_idx)
  );

  // one modify path shared: command operand while idle, read data after
  assign mod_op  = cmd_ready ? cmd_op      : op_q;
  assign mod_in  = cmd_ready ? cmd_operand : mem_rdata;
  assign mod_idx = cmd_ready ? gen_idx     : idx_q;

  bitop_modify #(.DATA_W(DATA_W)) mod_i (
    .op       (mod_op),
    .data_in  (mod_in),
    .idx      (mod_idx),
    .data_out (mod_out),
    .orig_bit (mod_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q       <= '0;
      addr_q     <= '0;
      idx_q      <= '0;
      val_q      <= '0;
      cf_q       <= 1'b0;
      flags_hi_q <= '0;
    end else if (load_cmd) begin
      op_q       <= cmd_op;
      addr_q     <= gen_addr;
      idx_q      <= gen_idx;
      val_q      <= mod_out;
      cf_q       <= mod_bit;
      flags_hi_q <= cmd_flags[FLAGS_W-1:1];
    end else if (load_rdata) begin
      val_q      <= mod_out;
      cf_q       <= mod_bit;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = val_q;
  assign res_cf    = cf_q;
  // for test the modify path leaves the read dword as it was
  assign res_value = val_q;
  assign res_flags = {flags_hi_q, cf_q};
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int ADDR_W  = 64,
  parameter int DATA_W  = 32,
  parameter int FLAGS_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_ready,
  input logic               res_valid,
  input logic               res_ready,
  input logic [DATA_W-1:0]  res_value,
  input logic               res_cf,
  input logic [FLAGS_W-1:0] res_flags,
  input logic               mem_req,
  input logic               mem_we,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic [DATA_W-1:0]  mem_wdata,
  input logic               mem_rvalid
);
  logic [ADDR_W-1:0] rd_addr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_addr_q <= '0;
    else if (mem_req && !mem_we) rd_addr_q <= mem_addr;
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R10
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_value) && $stable(res_cf) && $stable(res_flags)));

  // R10
  idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!mem_req && !res_valid));

  // R8
  wr_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr == rd_addr_q));

  // R8
  wr_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(mem_req && !mem_we && mem_rvalid));

  // R2
  cf_in_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_flags[0] == res_cf));
endmodule

bind bitop_unit bitop_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAGS_W(FLAGS_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_ready  (cmd_ready),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_value  (res_value),
  .res_cf     (res_cf),
  .res_flags  (res_flags),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_rvalid (mem_rvalid)
);

// File: tb/bitop_unit_tb_top.sv
`timescale 1ns/1ps
module bitop_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic        cmd_mem = 1'b0;
  logic        cmd_imm = 1'b0;
  logic [1:0]  cmd_asize = '0;
  logic [31:0] cmd_operand = '0;
  logic [31:0] cmd_offset = '0;
  logic [63:0] cmd_base = '0;
  logic [31:0] cmd_flags = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [31:0] res_value;
  logic        res_cf;
  logic [31:0] res_flags;
  logic        mem_req;
  logic        mem_we;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int failures = 0;
  int n_rd = 0;
  int n_wr = 0;
  logic [63:0] last_rd_addr = '0;
  logic [63:0] last_wr_addr = '0;
  logic [31:0] last_wr_data = '0;
  int dly = 0;

  always #5 clk = ~clk;

  bitop_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_mem(cmd_mem), .cmd_imm(cmd_imm), .cmd_asize(cmd_asize),
    .cmd_operand(cmd_operand), .cmd_offset(cmd_offset), .cmd_base(cmd_base),
    .cmd_flags(cmd_flags), .res_valid(res_valid), .res_ready(res_ready),
    .res_value(res_value), .res_cf(res_cf), .res_flags(res_flags),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] pat(input logic [63:0] a);
    return (a[31:0] * 32'h9E3779B1) ^ a[63:32] ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [31:0] ref_mod(input logic [1:0] op, input logic [31:0] v, input int idx);
    logic [31:0] r;
    r = v;
    if (op == 2'd1) r[idx] = 1'b1;
    else if (op == 2'd2) r[idx] = 1'b0;
    else if (op == 2'd3) r[idx] = ~v[idx];
    return r;
  endfunction

  function automatic logic [63:0] ref_addr(input logic [63:0] base, input logic [31:0] off,
                                           input logic imm, input logic [1:0] asz);
    logic signed [63:0] so;
    logic [63:0] a;
    so = 64'(signed'(off & 32'hFFFF_FFE0));
    a = imm ? base : base + 64'((so / 64'sd32) * 64'sd4);
    if (asz == 2'd0) a = {48'd0, a[15:0]};
    else if (asz == 2'd1) a = {32'd0, a[31:0]};
    return a;
  endfunction

  task automatic chk(input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", what, got, exp);
    end
  endtask

  // memory responder, driven at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rvalid) mem_rvalid = 1'b0;
      else if (mem_req) begin
        if (dly == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = pat(mem_addr);
          if (mem_we) begin
            n_wr++; last_wr_addr = mem_addr; last_wr_data = mem_wdata;
          end else begin
            n_rd++; last_rd_addr = mem_addr;
          end
          dly = int'($urandom % 3);
        end else dly--;
      end
    end
  end

  task automatic run_cmd(input logic [1:0] op, input logic mem, input logic imm,
                         input logic [1:0] asz, input logic [31:0] opnd,
                         input logic [31:0] off, input logic [63:0] base,
                         input logic [31:0] flg, input int stall);
    int rd0, wr0, idx;
    logic [63:0] ea;
    logic [31:0] orig, expv;
    rd0 = n_rd; wr0 = n_wr;
    @(negedge clk);
    cmd_op = op; cmd_mem = mem; cmd_imm = imm; cmd_asize = asz;
    cmd_operand = opnd; cmd_offset = off; cmd_base = base; cmd_flags = flg;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (stall > 0) res_ready = 1'b0;
    while (!res_valid) @(negedge clk);
    idx = int'(off[4:0]);
    ea = ref_addr(base, off, imm, asz);
    orig = mem ? pat(ea) : opnd;
    expv = ref_mod(op, orig, idx);
    if (stall > 0) begin
      for (int k = 0; k < stall; k++) @(negedge clk);
      chk("R10 result held under stall", {31'd0, res_valid}, 64'd1);
      res_ready = 1'b1;
    end
    chk("R1/R3 res_value", {32'd0, res_value}, {32'd0, expv});
    chk("R2 res_cf", {63'd0, res_cf}, {63'd0, orig[idx]});
    chk("R2 res_flags", {32'd0, res_flags}, {32'd0, flg[31:1], orig[idx]});
    if (!mem) begin
      chk("R4 no memory traffic", 64'(n_rd - rd0 + n_wr - wr0), 64'd0);
    end else begin
      chk("R8 one read", 64'(n_rd - rd0), 64'd1);
      chk("R5/R6/R7 read address", last_rd_addr, ea);
      chk("R8 write count", 64'(n_wr - wr0), (op == 2'd0) ? 64'd0 : 64'd1);
      if (op != 2'd0) begin
        chk("R8 write address", last_wr_addr, ea);
        chk("R8 write data", {32'd0, last_wr_data}, {32'd0, expv});
      end
    end
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h0BADC0DE));
    repeat (3) @(negedge clk);
    // R11
    chk("R11 cmd_ready after reset", {63'd0, cmd_ready}, 64'd1);
    chk("R11 res_valid after reset", {63'd0, res_valid}, 64'd0);
    chk("R11 mem_req after reset", {63'd0, mem_req}, 64'd0);
    rst_n = 1'b1;
    // R1 register form, offset taken modulo 32
    run_cmd(2'd1, 1'b0, 1'b0, 2'd2, 32'h0000_0000, 32'h0000_0041, 64'd0, 32'hFFFF_FFFF, 0);
    run_cmd(2'd3, 1'b0, 1'b0, 2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 32'h0000_0000, 0);
    run_cmd(2'd2, 1'b0, 1'b0, 2'd2, 32'h8000_0001, 32'd0, 64'd0, 32'h1234_5678, 0);
    run_cmd(2'd0, 1'b0, 1'b0, 2'd2, 32'h8000_0000, 32'd31, 64'd0, 32'h0, 0);
    // R5 offset -1 selects bit 31 of the dword 4 bytes below
    run_cmd(2'd1, 1'b1, 1'b0, 2'd2, 32'd0, 32'hFFFF_FFFF, 64'h1000, 32'h0, 0);
    run_cmd(2'd0, 1'b1, 1'b0, 2'd2, 32'd0, 32'hFFFF_FFDF, 64'h2000, 32'h0, 0);
    // R6 16-bit and 32-bit wrap, size 3 acts as 64
    run_cmd(2'd3, 1'b1, 1'b0, 2'd0, 32'd0, 32'd64, 64'h0000_0000_0000_FFFE, 32'h0, 0);
    run_cmd(2'd2, 1'b1, 1'b0, 2'd0, 32'd0, 32'hFFFF_FF80, 64'h0000_0000_0000_0004, 32'h0, 0);
    run_cmd(2'd1, 1'b1, 1'b0, 2'd1, 32'd0, 32'd32, 64'h0000_0001_FFFF_FFFC, 32'h0, 0);
    run_cmd(2'd1, 1'b1, 1'b0, 2'd3, 32'd0, 32'd32, 64'h0000_0001_FFFF_FFFC, 32'h0, 0);
    // R7 immediate: high offset bits ignored
    run_cmd(2'd3, 1'b1, 1'b1, 2'd2, 32'd0, 32'h1000_0025, 64'h4000, 32'h0, 0);
    run_cmd(2'd0, 1'b1, 1'b1, 2'd0, 32'd0, 32'hFFFF_FFE3, 64'h1_0001_2344, 32'h0, 0);
    // R10 stalled consumer
    run_cmd(2'd1, 1'b1, 1'b0, 2'd2, 32'd0, 32'd7, 64'h8000, 32'hAAAA_AAAA, 4);
    run_cmd(2'd2, 1'b0, 1'b0, 2'd2, 32'hFFFF_0000, 32'd20, 64'd0, 32'h5555_5555, 3);
    // random mix
    for (int n = 0; n < 300; n++) begin
      run_cmd(2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), $urandom, $urandom,
              {$urandom, $urandom}, $urandom, ($urandom % 8 == 0) ? 2 : 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired got=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule